// File: doc/BRIEF.md
# Interval Timer with Toggle Output

This block is a 16-bit up-counting interval timer. A prescaler turns the system clock into count ticks, and each tick advances the counter by one. When a tick arrives while the counter equals the compare value, the counter returns to zero. The same event raises a short match strobe and sets a sticky interrupt request flag. It can also invert the timer output pin. Software reaches all state through a byte-wide register port. The 16-bit compare value is written as two separate bytes.

The match strobe is produced by a small state machine with three states:

- `ST_IDLE`: the timer is stopped.
- `ST_COUNT`: the timer is counting and the strobe is low.
- `ST_STROBE`: the strobe is high.

Its transitions are:

- `ST_IDLE` goes to `ST_COUNT` when the run bit is set. It goes straight to `ST_STROBE` if a match event occurs in that same cycle.
- `ST_COUNT` goes to `ST_STROBE` on a match event.
- `ST_STROBE` returns to `ST_COUNT` when its hold count runs out. A fresh match event re-enters `ST_STROBE` and reloads the hold count.
- Any state goes to `ST_IDLE` when the run bit is cleared.

The hold count is half of the current division ratio, with a minimum of one system clock.

The output inverts on the rising edge of the strobe ANDed with the inversion enable. Setting the enable while the strobe is high therefore also inverts the output. There is no shadow buffer for the compare value, so the comparator always sees the raw register. To update the compare value safely, software masks the interrupt and disables inversion first. It then writes the high byte, then the low byte, and clears the flag. Only after the strobe has fallen does it re-enable the interrupt and inversion.

Top module: `itmr_top`

## Requirements
- R1: After reset every readable register reads 0, and `irq_o`, `match_o` and `tout_o` are 0.
- R2: The control register at address 0 holds run in bit 0, inversion enable in bit 1, interrupt mask in bit 2 (1 = masked) and the prescaler select in bits 4:3. Bits 7:5 read as 0. Address 1 is status: bit 0 is the request flag and bit 1 is the output level. Addresses 2 and 3 are the compare low and high bytes. Addresses 4 and 5 are the count low and high bytes. Addresses 6 and 7 read as 0.
- R3: The prescaler select values 0, 1, 2 and 3 give division ratios of 1, 2, 8 and 32. While run is 0, the counter and the prescaler are held at 0.
- R4: Two successive rises of `match_o` are (compare + 1) × division system clocks apart. At the rise, the counter reads 0.
- R5: `match_o` stays high for max(1, division/2) system clocks.
- R6: Each match sets the request flag. The flag stays set until software writes status with bit 0 = 1. Writing status with bit 0 = 0 leaves the flag unchanged.
- R7: `irq_o` equals the flag while the mask is 0, and is 0 while the mask is 1. The mask never stops the flag from being set.
- R8: `tout_o` inverts one clock after the rise of (strobe AND inversion enable). This includes the case where the enable is set while the strobe is high. Setting the enable while the strobe is low does not invert the output.
- R9: Each compare byte write takes effect immediately. After writing only the high byte, the comparator uses the new high byte with the old low byte.
- R10: A compare value written below the current count makes the counter wrap past 65535. The next interval is then about 65536 ticks longer than intended.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq_o | output | 1 | Interrupt request, the flag gated by the mask |
| match_o | output | 1 | Match strobe |
| tout_o | output | 1 | Timer output level |

## Verification
The assertions check four properties on every cycle. Every strobe rise coincides with a zero count and a set flag. A stopped timer always holds a zero count. The output level changes only right after a cycle in which the strobe and the inversion enable were both high. The strobe never stays high longer than the maximum hold allowed since the last match.

Other behaviours can only be shown by the bench scenarios:

- the exact interval and strobe width for each division ratio;
- the mixed compare value seen between the two byte writes;
- the long wrapped interval after lowering the compare value below the count;
- the toggle caused by setting the enable during the strobe;
- the sticky flag under the mask.

// File: rtl/itmr_pkg.sv
package itmr_pkg;
    localparam int unsigned ADDR_W   = 3;
    localparam int unsigned MAX_DIV  = 32;
    localparam int unsigned PRE_W    = $clog2(MAX_DIV);
    localparam int unsigned MAX_HALF = MAX_DIV / 2;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
    localparam logic [ADDR_W-1:0] A_CMPL = 3'd2;
    localparam logic [ADDR_W-1:0] A_CMPH = 3'd3;
    localparam logic [ADDR_W-1:0] A_CNTL = 3'd4;
    localparam logic [ADDR_W-1:0] A_CNTH = 3'd5;

    localparam int unsigned CB_RUN = 0;
    localparam int unsigned CB_INV = 1;
    localparam int unsigned CB_MSK = 2;
    localparam int unsigned CB_SEL = 3;
    localparam int unsigned SB_FLAG = 0;
    localparam int unsigned SB_OUT  = 1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_STROBE = 2'd2
    } strobe_st_t;

    function automatic logic [PRE_W:0] div_of(input logic [1:0] sel);
        logic [PRE_W:0] d;
        case (sel)
            2'd0:    d = (PRE_W+1)'(1);
            2'd1:    d = (PRE_W+1)'(2);
            2'd2:    d = (PRE_W+1)'(8);
            default: d = (PRE_W+1)'(MAX_DIV);
        endcase
        return d;
    endfunction
endpackage

// File: rtl/itmr_prescaler.sv
module itmr_prescaler
    import itmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [1:0]       sel,
    output logic             tick,
    output logic [PRE_W-1:0] half_len
);
    logic [PRE_W-1:0] pre_q;
    logic [PRE_W:0]   div;
    logic [PRE_W:0]   lim;
    logic [PRE_W-1:0] half_raw;

    always_comb begin
        div      = div_of(sel);
        lim      = div - (PRE_W+1)'(1);
        half_raw = div[PRE_W:1];
        tick     = run && ({1'b0, pre_q} >= lim);
        half_len = (half_raw == '0) ? PRE_W'(1) : half_raw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q <= '0;
        end else if (!run || tick) begin
            pre_q <= '0;
        end else begin
            pre_q <= pre_q + PRE_W'(1);
        end
    end
endmodule

// File: rtl/itmr_counter.sv
module itmr_counter #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] cmp,
    output logic [CNT_W-1:0] cnt,
    output logic             match_evt
);
    logic [CNT_W-1:0] cnt_q;

    assign cnt       = cnt_q;
    assign match_evt = tick && (cnt_q == cmp);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (!run || match_evt) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/itmr_strobe_fsm.sv
module itmr_strobe_fsm
    import itmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             match_evt,
    input  logic [PRE_W-1:0] half_len,
    output logic             strobe
);
    strobe_st_t       state_q, state_d;
    logic [PRE_W-1:0] hold_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (run && match_evt)  state_d = ST_STROBE;
                else if (run)          state_d = ST_COUNT;
            end
            ST_COUNT: begin
                if (!run)              state_d = ST_IDLE;
                else if (match_evt)    state_d = ST_STROBE;
            end
            ST_STROBE: begin
                if (!run)                        state_d = ST_IDLE;
                else if (match_evt)              state_d = ST_STROBE;
                else if (hold_q == PRE_W'(1))    state_d = ST_COUNT;
            end
            default:                   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hold_q  <= '0;
        end else begin
            state_q <= state_d;
            if (run && match_evt) begin
                hold_q <= half_len;
            end else if (state_q == ST_STROBE && hold_q != '0) begin
                hold_q <= hold_q - PRE_W'(1);
            end
        end
    end

    always_comb begin
        strobe = (state_q == ST_STROBE);
    end
endmodule

// File: rtl/itmr_toggle.sv
module itmr_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    input  logic inv_en,
    output logic tout
);
    logic gate, gate_q, tout_q;

    assign gate = strobe && inv_en;
    assign tout = tout_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gate_q <= 1'b0;
            tout_q <= 1'b0;
        end else begin
            gate_q <= gate;
            if (gate && !gate_q) begin
                tout_q <= !tout_q;
            end
        end
    end
endmodule

// File: rtl/itmr_regs.sv
module itmr_regs
    import itmr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                we,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                match_evt,
    input  logic                tout,
    input  logic [2*DATA_W-1:0] cnt,
    output logic [DATA_W-1:0]   rdata,
    output logic                run,
    output logic                inv_en,
    output logic                mask,
    output logic [1:0]          sel,
    output logic [2*DATA_W-1:0] cmp,
    output logic                flag
);
    localparam int unsigned CNT_W = 2 * DATA_W;

    logic             run_q, inv_q, msk_q, flag_q;
    logic [1:0]       sel_q;
    logic [CNT_W-1:0] cmp_q;

    assign run    = run_q;
    assign inv_en = inv_q;
    assign mask   = msk_q;
    assign sel    = sel_q;
    assign cmp    = cmp_q;
    assign flag   = flag_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q  <= 1'b0;
            inv_q  <= 1'b0;
            msk_q  <= 1'b0;
            sel_q  <= 2'd0;
            cmp_q  <= '0;
            flag_q <= 1'b0;
        end else begin
            if (we && addr == A_CTRL) begin
                run_q <= wdata[CB_RUN];
                inv_q <= wdata[CB_INV];
                msk_q <= wdata[CB_MSK];
                sel_q <= wdata[CB_SEL+1:CB_SEL];
            end
            if (we && addr == A_CMPL) cmp_q[DATA_W-1:0]     <= wdata;
            if (we && addr == A_CMPH) cmp_q[CNT_W-1:DATA_W] <= wdata;
            if (match_evt) begin
                flag_q <= 1'b1;
            end else if (we && addr == A_STAT && wdata[SB_FLAG]) begin
                flag_q <= 1'b0;
            end
        end
    end

    always_comb begin
        rdata = '0;
        case (addr)
            A_CTRL: begin
                rdata[CB_RUN]            = run_q;
                rdata[CB_INV]            = inv_q;
                rdata[CB_MSK]            = msk_q;
                rdata[CB_SEL+1:CB_SEL]   = sel_q;
            end
            A_STAT: begin
                rdata[SB_FLAG] = flag_q;
                rdata[SB_OUT]  = tout;
            end
            A_CMPL:  rdata = cmp_q[DATA_W-1:0];
            A_CMPH:  rdata = cmp_q[CNT_W-1:DATA_W];
            A_CNTL:  rdata = cnt[DATA_W-1:0];
            A_CNTH:  rdata = cnt[CNT_W-1:DATA_W];
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/itmr_top.sv
module itmr_top
    import itmr_pkg::*;
#(
    parameter int unsigned DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq_o,
    output logic              match_o,
    output logic              tout_o
);
    localparam int unsigned CNT_W = 2 * DATA_W;

    logic             run, inv_en, mask, flag, tick, match_evt, strobe, tout;
    logic [1:0]       sel;
    logic [CNT_W-1:0] cmp, cnt;
    logic [PRE_W-1:0] half_len;

    itmr_regs #(.DATA_W(DATA_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .match_evt(match_evt), .tout(tout), .cnt(cnt),
        .rdata(reg_rdata), .run(run), .inv_en(inv_en), .mask(mask),
        .sel(sel), .cmp(cmp), .flag(flag)
    );

    itmr_prescaler pre_i (
        .clk(clk), .rst_n(rst_n), .run(run), .sel(sel),
        .tick(tick), .half_len(half_len)
    );

    itmr_counter #(.CNT_W(CNT_W)) cnt_i (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .cmp(cmp),
        .cnt(cnt), .match_evt(match_evt)
    );

    itmr_strobe_fsm fsm_i (
        .clk(clk), .rst_n(rst_n), .run(run), .match_evt(match_evt),
        .half_len(half_len), .strobe(strobe)
    );

    itmr_toggle tog_i (
        .clk(clk), .rst_n(rst_n), .strobe(strobe), .inv_en(inv_en),
        .tout(tout)
    );

    assign irq_o   = flag && !mask;
    assign match_o = strobe;
    assign tout_o  = tout;
endmodule

// File: rtl/itmr_chk.sv
module itmr_chk
    import itmr_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        match_o,
    input logic        tout_o,
    input logic        run,
    input logic        inv_en,
    input logic        flag,
    input logic        match_evt,
    input logic [15:0] cnt
);
    logic [7:0] len_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          len_q <= '0;
        else if (match_evt)  len_q <= 8'd1;
        else if (match_o)    len_q <= len_q + 8'd1;
        else                 len_q <= '0;
    end

    // R4
    rise_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_o) |-> (cnt == 16'd0));

    // R6
    rise_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(match_o) |-> flag);

    // R3
    stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (cnt == 16'd0));

    // R8
    tout_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(tout_o) |-> ($past(match_o) && $past(inv_en)));

    // R5
    strobe_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> (len_q != 8'd0 && len_q <= 8'(MAX_HALF)));
endmodule

bind itmr_top itmr_chk chk_i (
    .clk(clk), .rst_n(rst_n), .match_o(match_o), .tout_o(tout_o),
    .run(run), .inv_en(inv_en), .flag(flag), .match_evt(match_evt),
    .cnt(cnt)
);

// File: tb/itmr_top_tb_top.sv
module itmr_top_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_we = 1'b0;
    logic [2:0] reg_addr = 3'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq_o, match_o, tout_o;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = !clk;

    itmr_top dut_i (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
        .match_o(match_o), .tout_o(tout_o)
    );

    // control bits: run=bit0, inv=bit1, mask=bit2, sel=bits4:3
    localparam logic [7:0] RUN = 8'h01;
    localparam logic [7:0] INV = 8'h02;
    localparam logic [7:0] MSK = 8'h04;

    localparam int NV = 6;
    localparam int V_SEL [NV] = '{0, 1, 2, 3, 1, 2};
    localparam int V_CMP [NV] = '{4, 3, 2, 1, 0, 0};
    localparam int V_PER [NV] = '{5, 8, 24, 64, 2, 8};
    localparam int V_WID [NV] = '{1, 1, 4, 16, 1, 4};

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output int d);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic sync_rise(output int n);
        logic prev;
        prev = match_o;
        n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            if (match_o && !prev) break;
            prev = match_o;
        end
    endtask

    task automatic measure(output int per, output int wid);
        logic prev, first;
        prev = 1'b1; first = 1'b1; per = 0; wid = 1;
        while (1) begin
            @(negedge clk);
            per++;
            if (first && match_o) wid++;
            else first = 1'b0;
            if (match_o && !prev) break;
            prev = match_o;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int v, p, w, n;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v);
            chk("R1 reset readback", v, 0);
        end
        chk("R1 irq_o reset", int'(irq_o), 0);
        chk("R1 match_o reset", int'(match_o), 0);
        chk("R1 tout_o reset", int'(tout_o), 0);

        // R2 control layout, upper bits read 0
        wr(3'd0, 8'hFE);
        rd(3'd0, v);
        chk("R2 ctrl readback", v, 8'h1E);
        chk("R2 no strobe while stopped", int'(match_o), 0);
        wr(3'd0, 8'h00);
        wr(3'd2, 8'hA5);
        rd(3'd2, v);
        chk("R2 cmp low readback", v, 8'hA5);

        // R3/R4/R5 vector table
        for (int i = 0; i < NV; i++) begin
            wr(3'd0, 8'h00);
            @(negedge clk);
            rd(3'd4, v);
            chk("R3 count held at zero when stopped", v, 0);
            wr(3'd3, 8'h00);
            wr(3'd2, 8'(V_CMP[i]));
            wr(3'd0, RUN | 8'(V_SEL[i] << 3));
            sync_rise(n);
            measure(p, w);
            rd(3'd4, v);
            chk("R4 count zero at strobe rise", v, 0);
            chk("R4 interval (cmp+1)*div", p, V_PER[i]);
            chk("R5 strobe width", w, V_WID[i]);
        end

        // R6/R7 flag and mask
        wr(3'd0, 8'h00);
        rd(3'd1, v);
        chk("R6 flag set by match", v & 1, 1);
        chk("R7 irq follows flag unmasked", int'(irq_o), 1);
        wr(3'd0, MSK);
        chk("R7 irq blocked by mask", int'(irq_o), 0);
        rd(3'd1, v);
        chk("R7 mask keeps flag", v & 1, 1);
        wr(3'd1, 8'h00);
        rd(3'd1, v);
        chk("R6 write bit0=0 keeps flag", v & 1, 1);
        wr(3'd1, 8'h01);
        rd(3'd1, v);
        chk("R6 write bit0=1 clears flag", v & 1, 0);
        wr(3'd2, 8'h03);
        wr(3'd0, MSK | RUN);
        sync_rise(n);
        rd(3'd1, v);
        chk("R7 flag still set under mask", v & 1, 1);
        chk("R7 irq low under mask", int'(irq_o), 0);
        wr(3'd0, 8'h00);
        wr(3'd0, 8'h00 | 8'h00);
        chk("R7 irq at once when unmasked", int'(irq_o), 1);
        wr(3'd1, 8'h01);

        // R8 output toggle
        wr(3'd2, 8'h01);
        wr(3'd0, RUN | 8'h18);
        sync_rise(n);
        chk("R8 output low before enable", int'(tout_o), 0);
        wr(3'd0, RUN | INV | 8'h18);
        @(negedge clk);
        rd(3'd1, v);
        chk("R8 enable during strobe toggles", (v >> 1) & 1, 1);
        while (match_o) @(negedge clk);
        wr(3'd0, RUN | 8'h18);
        wr(3'd0, RUN | INV | 8'h18);
        repeat (2) @(negedge clk);
        chk("R8 enable outside strobe no toggle", int'(tout_o), 1);
        sync_rise(n);
        repeat (2) @(negedge clk);
        chk("R8 toggle on match", int'(tout_o), 0);
        sync_rise(n);
        repeat (2) @(negedge clk);
        chk("R8 toggle on next match", int'(tout_o), 1);

        // R9 mixed compare between byte writes
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd2, 8'h03);
        wr(3'd3, 8'h01);
        rd(3'd2, v);
        chk("R9 old low byte kept", v, 3);
        rd(3'd3, v);
        chk("R9 new high byte", v, 1);
        wr(3'd0, RUN);
        sync_rise(n);
        measure(p, w);
        chk("R9 interval uses mixed value 0x0103", p, 260);

        // R10 compare lowered below count
        wr(3'd0, 8'h00);
        wr(3'd3, 8'h00);
        wr(3'd2, 8'd100);
        wr(3'd0, RUN);
        sync_rise(n);
        measure(p, w);
        chk("R10 base interval", p, 101);
        repeat (40) @(negedge clk);
        wr(3'd2, 8'd10);
        sync_rise(n);
        n = n + 42;
        if (n >= 65540 && n <= 65555) chk("R10 wrapped interval", n, n);
        else chk("R10 wrapped interval", n, 65547);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule